// File: doc/BRIEF.md
# Double-Buffered Raster Bank Controller

This block produces the pixel timing for a progressive raster display from one pixel clock, and it decides which of two frame-memory banks the display reads. A horizontal counter and a vertical counter give the current pixel position. Horizontal sync, vertical sync and a video-active flag are decoded from that position. The display-side bank select and its complement, the host-side select, steer the two memories. The display reads one bank while the host fills the other.

When the host has finished a new frame, it raises `host_ready`. This input is synchronous to `clk`. The controller looks at `host_ready` only on the last pixel of the last line. If the flag is high there and the controller is armed, both selects flip on the next edge. The first pixel of the next frame therefore comes from the freshly written bank, and the picture never tears. A one-cycle `swap_ack` pulse tells the host the swap has happened. The controller re-arms only after it has seen `host_ready` low, so a flag that stays high cannot cause a second swap.

The default timing is 800x600 at 60 Hz with a 40 MHz pixel clock. The horizontal line is 800 visible, 40 front porch, 128 sync and 88 back porch pixels. The frame is 600 visible, 1 front porch, 4 sync and 23 back porch lines. Both sync pulses are active high.

Top module: `vga_dbuf_ctrl`

## Requirements
- R1: `pix_x` counts 0 to H_TOTAL-1 (H_VIS+H_FP+H_SYNC+H_BP) by one per clock and then wraps to 0. `pix_y` advances by one on each wrap of `pix_x` and returns to 0 after line V_TOTAL-1.
- R2: `hsync` is high exactly when H_VIS+H_FP <= `pix_x` < H_VIS+H_FP+H_SYNC (840 to 967 by default).
- R3: `vsync` is high exactly when V_VIS+V_FP <= `pix_y` < V_VIS+V_FP+V_SYNC (601 to 604 by default).
- R4: `video_active` is high exactly when `pix_x` < H_VIS and `pix_y` < V_VIS.
- R5: `disp_bank` toggles on the clock edge that ends the cycle in which `pix_x`=H_TOTAL-1, `pix_y`=V_TOTAL-1, `host_ready`=1 and the controller is armed. Pixel (0,0) of the next frame therefore shows the new bank.
- R6: `host_ready` sampled on any edge other than the frame-end edge has no effect on `disp_bank`.
- R7: `swap_ack` is high for exactly one cycle per swap. That cycle is the first one in which `disp_bank` shows its new value, with `pix_x`=0 and `pix_y`=0.
- R8: After reset, and after every swap, the controller is disarmed. It arms only after `host_ready` has been 0 on at least one clock edge. A `host_ready` that stays high at a frame end while disarmed changes nothing.
- R9: `host_bank` is always the complement of `disp_bank`.
- R10: `pix_addr` equals {`disp_bank`, `pix_y`, `pix_x`}. The bank is the most significant bit and `pix_x` occupies the lowest $clog2(H_TOTAL) bits.
- R11: `rst_n` low asynchronously forces `pix_x`=0, `pix_y`=0, `disp_bank`=0, `swap_ack`=0 and the disarmed state. After `rst_n` rises, the block holds this state through two more clock edges and starts counting on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_ready | input | 1 | Host has finished the next frame (synchronous to clk) |
| pix_x | output | $clog2(H_TOTAL) | Horizontal pixel position |
| pix_y | output | $clog2(V_TOTAL) | Vertical line position |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| video_active | output | 1 | High inside the visible area |
| disp_bank | output | 1 | Bank the display reads |
| host_bank | output | 1 | Bank the host writes |
| pix_addr | output | 1+$clog2(V_TOTAL)+$clog2(H_TOTAL) | Display memory address {bank, y, x} |
| swap_ack | output | 1 | One-cycle pulse when the banks have swapped |

## Verification
The frame-end check and a change of `host_ready` can fall on the same edge. The sharpest case is `host_ready` rising in the very cycle of the last pixel, so the only sample that counts is the frame-end one. The bench provokes this by driving the flag high right after the edge that brings the raster to its last position. Around it, the bench also places mid-frame pulses, a flag held high across a later frame end, and back-to-back swaps in consecutive frames. A reference model predicts every bank, acknowledge and position value cycle by cycle from the rules, and the ack pulses counted at the ports must match the number of swaps those rules allow.

// File: rtl/vga_bank_pkg.sv
package vga_bank_pkg;

  // True when v lies in the half-open window [lo, lo+len).
  function automatic logic in_window(input int unsigned v,
                                     input int unsigned lo,
                                     input int unsigned len);
    return (v >= lo) && (v < lo + len);
  endfunction

  typedef enum logic {
    BANK_LOW  = 1'b0,
    BANK_HIGH = 1'b1
  } bank_e;

endpackage

// File: rtl/vga_rst_sync.sv
module vga_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_out = stage_q[STAGES-1];

endmodule

// File: rtl/vga_raster_counter.sv
module vga_raster_counter #(
  parameter  int H_TOTAL = 1056,
  parameter  int V_TOTAL = 628,
  localparam int XW      = $clog2(H_TOTAL),
  localparam int YW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          line_last,
  output logic          frame_last
);

  localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);

  logic [XW-1:0] x_d;
  logic [YW-1:0] y_d;
  logic          y_en;

  always_comb begin
    line_last  = (x == X_LAST);
    frame_last = line_last && (y == Y_LAST);
    x_d        = line_last ? '0 : x + 1'b1;
    y_en       = line_last;
    y_d        = (y == Y_LAST) ? '0 : y + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
    end else begin
      x <= x_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y <= '0;
    end else if (y_en) begin
      y <= y_d;
    end
  end

  p_x_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(x) < H_TOTAL);
  p_y_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(y) < V_TOTAL);
  p_x_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |=> (x == '0));
  p_y_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_last |=> $stable(y));

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
  import vga_bank_pkg::*;
#(
  parameter int H_VIS  = 800,
  parameter int H_FP   = 40,
  parameter int H_SYNC = 128,
  parameter int V_VIS  = 600,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 4,
  parameter int XW     = 11,
  parameter int YW     = 10
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output logic          hsync,
  output logic          vsync,
  output logic          active
);

  localparam int unsigned HS_START = H_VIS + H_FP;
  localparam int unsigned VS_START = V_VIS + V_FP;

  always_comb begin
    hsync  = in_window(int'(x), HS_START, H_SYNC);
    vsync  = in_window(int'(y), VS_START, V_SYNC);
    active = (int'(x) < H_VIS) && (int'(y) < V_VIS);
  end

endmodule

// File: rtl/vga_bank_ctrl.sv
module vga_bank_ctrl
  import vga_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_last,
  input  logic ready,
  output logic disp_bank,
  output logic swap_ack
);

  bank_e bank_q, bank_d;
  logic  armed_q, armed_d;
  logic  ack_q, ack_d;
  logic  swap;

  always_comb begin
    swap    = frame_last && armed_q && ready;
    bank_d  = swap ? bank_e'(~bank_q) : bank_q;
    ack_d   = swap;
    if (swap) begin
      armed_d = 1'b0;
    end else if (!ready) begin
      armed_d = 1'b1;
    end else begin
      armed_d = armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= BANK_LOW;
      armed_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      armed_q <= armed_d;
      ack_q   <= ack_d;
    end
  end

  assign disp_bank = bank_q;
  assign swap_ack  = ack_q;

  p_bank_frame_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(frame_last));
  p_midframe_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(bank_q));
  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  p_ack_with_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (bank_q != $past(bank_q)));
  p_disarmed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && !armed_q) |=> ($stable(bank_q) && !ack_q));
  p_disarm_after_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !armed_q);

endmodule

// File: rtl/vga_dbuf_ctrl.sv
module vga_dbuf_ctrl #(
  parameter  int H_VIS   = 800,
  parameter  int H_FP    = 40,
  parameter  int H_SYNC  = 128,
  parameter  int H_BP    = 88,
  parameter  int V_VIS   = 600,
  parameter  int V_FP    = 1,
  parameter  int V_SYNC  = 4,
  parameter  int V_BP    = 23,
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int XW      = $clog2(H_TOTAL),
  localparam int YW      = $clog2(V_TOTAL),
  localparam int AW      = 1 + YW + XW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ready,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic          hsync,
  output logic          vsync,
  output logic          video_active,
  output logic          disp_bank,
  output logic          host_bank,
  output logic [AW-1:0] pix_addr,
  output logic          swap_ack
);

  logic rst_n_sync;
  logic line_last;
  logic frame_last;

  vga_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  vga_raster_counter #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL)
  ) u_raster (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .x          (pix_x),
    .y          (pix_y),
    .line_last  (line_last),
    .frame_last (frame_last)
  );

  vga_sync_gen #(
    .H_VIS  (H_VIS),
    .H_FP   (H_FP),
    .H_SYNC (H_SYNC),
    .V_VIS  (V_VIS),
    .V_FP   (V_FP),
    .V_SYNC (V_SYNC),
    .XW     (XW),
    .YW     (YW)
  ) u_sync (
    .x      (pix_x),
    .y      (pix_y),
    .hsync  (hsync),
    .vsync  (vsync),
    .active (video_active)
  );

  vga_bank_ctrl u_bank (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .frame_last (frame_last),
    .ready      (host_ready),
    .disp_bank  (disp_bank),
    .swap_ack   (swap_ack)
  );

  assign host_bank = ~disp_bank;
  assign pix_addr  = {disp_bank, pix_y, pix_x};

  p_hsync_blank_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    hsync |-> !video_active);
  p_vsync_blank_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    vsync |-> !video_active);
  p_ack_at_origin_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    swap_ack |-> (pix_x == '0 && pix_y == '0));
  p_line_end_blank_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    line_last |-> !video_active);

endmodule

// File: tb/vga_dbuf_ctrl_bench.sv
module vga_dbuf_ctrl_bench;

  localparam int HV = 8, HF = 2, HS = 3, HB = 2;
  localparam int VV = 6, VF = 1, VS = 2, VB = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int FRAME = HT * VT;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);
  localparam int AW = 1 + YW + XW;

  logic          clk;
  logic          rst_n;
  logic          host_ready;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;
  logic          hsync, vsync, video_active;
  logic          disp_bank, host_bank, swap_ack;
  logic [AW-1:0] pix_addr;

  vga_dbuf_ctrl #(
    .H_VIS (HV), .H_FP (HF), .H_SYNC (HS), .H_BP (HB),
    .V_VIS (VV), .V_FP (VF), .V_SYNC (VS), .V_BP (VB)
  ) u_vga_dbuf_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_ready   (host_ready),
    .pix_x        (pix_x),
    .pix_y        (pix_y),
    .hsync        (hsync),
    .vsync        (vsync),
    .video_active (video_active),
    .disp_bank    (disp_bank),
    .host_bank    (host_bank),
    .pix_addr     (pix_addr),
    .swap_ack     (swap_ack)
  );

  typedef struct {
    int x;
    int y;
    int bank;
    int ack;
    int btag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   adv   = 0;
  int   phase = 0;
  int   acks_p1 = 0;
  int   acks_p2 = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check_eq(input string tag, input string what,
                          input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string bank_tag(input int k);
    case (k)
      6:       return "R6";
      8:       return "R8";
      default: return "R5";
    endcase
  endfunction

  // Predictor: advances the reference model on each edge, pushes expectations.
  initial begin
    int   t;
    int   p;
    int   mbank;
    int   armed;
    int   r;
    int   sw;
    int   tg;
    exp_t e;
    t = 0; mbank = 0; armed = 0;
    forever begin
      @(posedge clk);
      r = int'(host_ready);
      if (!rst_n) begin
        t = 0; adv = 0; mbank = 0; armed = 0;
      end else begin
        t++;
        if (t <= 2) begin
          e.x = 0; e.y = 0; e.bank = 0; e.ack = 0; e.btag = 5;
        end else begin
          p  = adv % FRAME;
          sw = (p == FRAME - 1 && armed == 1 && r == 1) ? 1 : 0;
          if (p == FRAME - 1 && r == 1 && armed == 0) tg = 8;
          else if (p != FRAME - 1 && r == 1)          tg = 6;
          else                                        tg = 5;
          if (sw == 1)      armed = 0;
          else if (r == 0)  armed = 1;
          mbank = mbank ^ sw;
          adv++;
          p = adv % FRAME;
          e.x = p % HT; e.y = p / HT; e.bank = mbank; e.ack = sw; e.btag = tg;
        end
        q.push_back(e);
      end
    end
  end

  // Monitor: pops expectations and compares at the falling edge.
  initial begin
    exp_t e;
    int   hs_e, vs_e, act_e, addr_e;
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        hs_e   = (e.x >= HV + HF && e.x < HV + HF + HS) ? 1 : 0;
        vs_e   = (e.y >= VV + VF && e.y < VV + VF + VS) ? 1 : 0;
        act_e  = (e.x < HV && e.y < VV) ? 1 : 0;
        addr_e = (e.bank << (XW + YW)) | (e.y << XW) | e.x;
        check_eq("R1", "pix_x", int'(pix_x), e.x);
        check_eq("R1", "pix_y", int'(pix_y), e.y);
        check_eq("R2", "hsync", int'(hsync), hs_e);
        check_eq("R3", "vsync", int'(vsync), vs_e);
        check_eq("R4", "video_active", int'(video_active), act_e);
        check_eq(bank_tag(e.btag), "disp_bank", int'(disp_bank), e.bank);
        check_eq("R7", "swap_ack", int'(swap_ack), e.ack);
        check_eq("R9", "host_bank", int'(host_bank), 1 - e.bank);
        check_eq("R10", "pix_addr", int'(pix_addr), addr_e);
        if (swap_ack && phase == 1) acks_p1++;
        if (swap_ack && phase == 2) acks_p2++;
      end
    end
  end

  task automatic wait_adv(input int target);
    do begin
      @(posedge clk);
      #1;
    end while (adv != target);
  endtask

  task automatic set_ready_at(input int frame, input int pos, input logic v);
    wait_adv(frame * FRAME + pos);
    host_ready = v;
  endtask

  // R11: reset state at the ports
  task automatic reset_checks();
    repeat (3) begin
      @(negedge clk);
      check_eq("R11", "pix_x in reset", int'(pix_x), 0);
      check_eq("R11", "pix_y in reset", int'(pix_y), 0);
      check_eq("R11", "disp_bank in reset", int'(disp_bank), 0);
      check_eq("R11", "host_bank in reset", int'(host_bank), 1);
      check_eq("R11", "swap_ack in reset", int'(swap_ack), 0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    host_ready = 1'b1;
    reset_checks();
    @(negedge clk); #1 rst_n = 1'b1;
    phase = 1;
    // R8: ready held high out of reset, no swap at end of frame 0
    set_ready_at(1, 20, 1'b0);
    // R6: mid-frame pulse, no swap at end of frame 1
    set_ready_at(1, 30, 1'b1);
    set_ready_at(1, 50, 1'b0);
    // R5: ready rises on the frame-end cycle itself
    set_ready_at(2, FRAME - 1, 1'b1);
    // R8: held high across frame 3 end, no second swap
    set_ready_at(4, 10, 1'b0);
    set_ready_at(4, 60, 1'b1);
    // back-to-back swaps at the ends of frames 4 and 5
    set_ready_at(5, 5, 1'b0);
    set_ready_at(5, FRAME - 2, 1'b1);
    set_ready_at(6, 3, 1'b0);
    wait_adv(7 * FRAME + 70);
    @(negedge clk); #1 rst_n = 1'b0;
    check_eq("R7", "swaps seen in phase 1", acks_p1, 3);
    phase = 2;
    reset_checks();
    @(negedge clk); #1 rst_n = 1'b1;
    set_ready_at(0, 40, 1'b1);
    set_ready_at(1, 20, 1'b0);
    wait_adv(FRAME + 100);
    check_eq("R5", "swaps seen in phase 2", acks_p2, 1);
    check_eq("R5", "bank after phase 2", int'(disp_bank), 1);
    finish_run();
  end

endmodule